// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the slave side of a 1 KiB serial memory that is reached over a four-wire SPI-style bus. The bus has an active-low select, a serial clock, a data input and a data output. The controller runs on a system clock `clk`. It treats `cs_n`, `sclk` and `sdi` as inputs that are already synchronous to `clk`, and it finds the serial clock edges by sampling. For this to work, each high and each low phase of `sclk` must last at least two `clk` cycles.

Each selection begins with an 8-bit opcode. The opcode is followed by a two-byte address and data, or by a status byte. The controller serves six commands: write-latch set, write-latch clear, status read, status write, array read and array write. The storage array is held in on-chip flops. Array and status writes are first collected in a staging buffer. They are committed only when the select is released on a clean byte boundary. The commit starts a self-timed programming cycle. A cycle counter models that cycle, and its busy flag is visible on `wip`.

The interfaces are the plain serial pins and one busy flag. There is no handshake and no back-pressure: the bus master sets the pace with `sclk`.

Top module: `spiee_ctrl`

## Requirements
- R1: Both clock idle levels are supported, idle-low (mode 0,0) and idle-high (mode 1,1). `sdi` is sampled on the rising `sclk` edge and `sdo` changes on the falling edge. Every opcode, address and data byte travels most significant bit first.
- R2: Opcode 0x06 sets the write latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte, laid out as {stored bits [7:2], write latch at bit 1, busy at bit 0}. The status byte is repeated for as long as clocks continue.
- R3: After reset, the status byte reads 0x00, every memory byte is 0x00, `wip` is low and `sdo` is high-impedance.
- R4: Opcode 0x03 is followed by a 16-bit address, of which only the low 10 bits are used. It then streams bytes from consecutive addresses, and the address wraps from 0x3FF to 0x000.
- R5: Opcode 0x02 is followed by a 16-bit address and 1 to 32 data bytes. The address wraps within the current 32-byte page. The data reaches the array only if the select rises after a whole number of data bytes, with at least one byte received. Any other release discards the data and starts no programming cycle.
- R6: A write whose address falls in the first page (0x000 to 0x01F) changes no memory byte.
- R7: While the write latch is clear, array-write and status-write commands are ignored.
- R8: A committed write raises `wip` in the cycle after the select rise is seen. `wip` then stays high for exactly PROG_CYCLES clock cycles, and the write latch is cleared when the cycle ends.
- R9: While `wip` is high, only the status read is served. Every other opcode is ignored and `sdo` stays high-impedance.
- R10: After opcode 0x06, 0x04 or 0x05, the controller ignores all further bits until it is deselected.
- R11: `sdo` is high-impedance whenever `cs_n` is high, and whenever the current command returns no data.
- R12: Opcode 0x01 with the write latch set takes one byte. Its bits [7:2] become the stored status bits when the programming cycle ends. The byte is committed only if the select rises right after its eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data into the controller |
| sdo | output | 1 | Serial data out, high-impedance when not driving |
| wip | output | 1 | Programming cycle in progress |

## Verification
On every cycle, the assertions check the following. `wip` can rise only from a commit, and it rises straight after one. The programming counter never exceeds its load value. The array never takes a write to the first page. A deselect always clears the bit position. Other behaviours only show up in the bench's sequences: byte-boundary cancellation, page and address wrap, the exact length of the busy window, and the parking after status-only opcodes. The bench also shows that commands are ignored while busy, and that reads work in both clock idle levels.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_WDAT, ST_RDAT, ST_STAT, ST_SWR, ST_SWDONE, ST_HOLD
  } spiee_st_t;

  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_ARR_RD    = 8'h03;
  localparam logic [7:0] OP_ARR_WR    = 8'h02;
endpackage

// File: rtl/spiee_edges.sv
module spiee_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  assign sck_rise = sclk & ~sclk_q;
  assign sck_fall = ~sclk & sclk_q;
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/spiee_timer.sv
module spiee_timer #(
  parameter int unsigned CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (start)           cnt <= CW'(CYC);
    else if (cnt != '0)       cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CYC)); // R8
endmodule

// File: rtl/spiee_array.sv
module spiee_array #(
  parameter int unsigned AW = 10,
  parameter int unsigned PW = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 rd_addr,
  output logic [7:0]                    rd_data,
  input  logic                          we,
  input  logic [AW-PW-1:0]              wpage,
  input  logic [(1<<PW)-1:0][7:0]       wdat,
  input  logic [(1<<PW)-1:0]            wmask
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PGSZ  = 1 << PW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wpage == (AW-PW)'(i / PGSZ) && wmask[i % PGSZ])
          mem[i] <= wdat[i % PGSZ];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  AST_NO_PAGE0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wpage != '0)); // R6
endmodule

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int unsigned MEM_AW      = 10,
  parameter int unsigned PAGE_AW     = 5,
  parameter int unsigned ADDR_BYTES  = 2,
  parameter int unsigned PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output wire  sdo,
  output logic wip
);
  localparam int unsigned PGSZ = 1 << PAGE_AW;
  localparam int unsigned ABW  = 8 * ADDR_BYTES;
  localparam int unsigned ACW  = $clog2(ADDR_BYTES + 1);

  logic sck_rise, sck_fall, cs_rise;
  logic busy, done;

  spiee_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  spiee_st_t              st;
  logic [2:0]             bcnt;
  logic [7:0]             sh, sh_nx;
  logic [ABW-1:0]         ash, ash_nx;
  logic [ACW-1:0]         acnt;
  logic [MEM_AW-1:0]      cur, rd_addr;
  logic [7:0]             rd_data;
  logic [7:0]             osh;
  logic                   obit;
  logic                   is_wr, got, wel, stp;
  logic [5:0]             stat, st_new;
  logic [PGSZ-1:0][7:0]   pbuf;
  logic [PGSZ-1:0]        mask;
  logic                   wr_commit, st_commit, prog_start;
  logic [7:0]             status;

  assign sh_nx  = {sh[6:0], sdi};
  assign ash_nx = {ash[ABW-9:0], sh_nx};
  assign status = {stat, wel, busy};

  assign rd_addr = (st == ST_ADDR) ? ash_nx[MEM_AW-1:0] : cur + MEM_AW'(1);

  assign wr_commit  = cs_rise && st == ST_WDAT && bcnt == 3'd0 && got &&
                      cur[MEM_AW-1:PAGE_AW] != '0;
  assign st_commit  = cs_rise && st == ST_SWDONE;
  assign prog_start = wr_commit | st_commit;

  spiee_timer #(.CYC(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(done)
  );

  spiee_array #(.AW(MEM_AW), .PW(PAGE_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .we(wr_commit), .wpage(cur[MEM_AW-1:PAGE_AW]), .wdat(pbuf), .wmask(mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_CMD; bcnt <= '0; sh <= '0; ash <= '0; acnt <= '0;
      cur <= '0; osh <= '0; obit <= 1'b0; is_wr <= 1'b0; got <= 1'b0;
      wel <= 1'b0; stp <= 1'b0; stat <= '0; st_new <= '0;
      pbuf <= '0; mask <= '0;
    end else begin
      if (done) begin
        wel <= 1'b0;
        stp <= 1'b0;
        if (stp) stat <= st_new;
      end
      if (st_commit) stp <= 1'b1;

      if (cs_n) begin
        st <= ST_CMD; bcnt <= '0; acnt <= '0;
      end else if (sck_rise) begin
        bcnt <= bcnt + 3'd1;
        sh   <= sh_nx;
        if (st == ST_SWDONE) st <= ST_HOLD;
        if (bcnt == 3'd7) begin
          unique case (st)
            ST_CMD: begin
              unique case (sh_nx)
                OP_LATCH_SET: begin if (!busy) wel <= 1'b1; st <= ST_HOLD; end
                OP_LATCH_CLR: begin if (!busy) wel <= 1'b0; st <= ST_HOLD; end
                OP_STAT_RD:   begin st <= ST_STAT; osh <= status; end
                OP_ARR_RD:    begin st <= busy ? ST_HOLD : ST_ADDR; is_wr <= 1'b0; end
                OP_ARR_WR:    begin st <= (busy || !wel) ? ST_HOLD : ST_ADDR; is_wr <= 1'b1; end
                OP_STAT_WR:   st <= (busy || !wel) ? ST_HOLD : ST_SWR;
                default:      st <= ST_HOLD;
              endcase
            end
            ST_ADDR: begin
              ash  <= ash_nx;
              acnt <= acnt + ACW'(1);
              if (acnt == ACW'(ADDR_BYTES - 1)) begin
                cur <= ash_nx[MEM_AW-1:0];
                if (is_wr) begin
                  st <= ST_WDAT; mask <= '0; got <= 1'b0;
                end else begin
                  st <= ST_RDAT; osh <= rd_data;
                end
              end
            end
            ST_WDAT: begin
              pbuf[cur[PAGE_AW-1:0]] <= sh_nx;
              mask[cur[PAGE_AW-1:0]] <= 1'b1;
              cur <= {cur[MEM_AW-1:PAGE_AW], cur[PAGE_AW-1:0] + PAGE_AW'(1)};
              got <= 1'b1;
            end
            ST_RDAT: begin
              cur <= cur + MEM_AW'(1);
              osh <= rd_data;
            end
            ST_STAT: osh <= status;
            ST_SWR: begin
              st_new <= sh_nx[7:2];
              st     <= ST_SWDONE;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && (st == ST_RDAT || st == ST_STAT)) begin
        obit <= osh[7];
        osh  <= {osh[6:0], 1'b0};
      end
    end
  end

  assign sdo = (!cs_n && (st == ST_RDAT || st == ST_STAT)) ? obit : 1'bz;
  assign wip = busy;

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy); // R8
  AST_BUSY_ONLY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_start)); // R8
  AST_DESELECT_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bcnt == 3'd0)); // R5
endmodule

// File: tb/test_spiee_ctrl.sv
module test_spiee_ctrl;
  localparam int CLK_PER = 10;
  localparam int HALF    = 4;
  localparam int PROG    = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  wire  sdo;
  logic wip;
  logic cpol = 1'b0;
  int   n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  spiee_ctrl #(.PROG_CYCLES(PROG)) i_spiee_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .wip(wip)
  );

  // address, data written, value expected on read-back
  localparam logic [31:0] VEC [6] = '{
    {16'h0040, 8'hA5, 8'hA5},
    {16'h03FF, 8'h3C, 8'h3C},
    {16'h0005, 8'h77, 8'h00},
    {16'h0120, 8'h81, 8'h81},
    {16'h001F, 8'hFF, 8'h00},
    {16'h0200, 8'h5A, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel();
    sclk = cpol; half();
    cs_n = 1'b0; half();
  endtask

  task automatic desel();
    if (!cpol) sclk = 1'b0;
    half();
    cs_n = 1'b1; half(); half();
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; sdi = tx[i]; half();
      rx[i] = sdo;
      sclk = 1'b1; half();
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wait_idle();
    int k = 0;
    while (wip && k < 5000) begin @(negedge clk); k++; end
    half();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r;
    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(d, r); desel();
    wait_idle();
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] r;
    sel(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(8'h00, d); desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d, d2, r;
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    half();

    // R3: reset state
    chk("R3 sdo hiz", {31'd0, sdo === 1'bz}, 32'd1);
    chk("R3 wip", {31'd0, wip}, 32'd0);
    rdsr(s);
    chk("R3 status", {24'd0, s}, 32'h00);
    rd(16'h0200, d);
    chk("R3 memory zero", {24'd0, d}, 32'h00);

    // R4 R5 R6: table of writes and read-backs
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][31:16], VEC[i][15:8]);
      rd(VEC[i][31:16], d);
      chk($sformatf("R5 R6 vector %0d", i), {24'd0, d}, {24'd0, VEC[i][7:0]});
    end

    // R2: latch set / clear visible in status
    cmd1(8'h06); rdsr(s);
    chk("R2 latch set", {24'd0, s}, 32'h02);
    cmd1(8'h04); rdsr(s);
    chk("R2 latch clear", {24'd0, s}, 32'h00);

    // R7: write without latch ignored
    sel(); xfer(8'h02, r); xfer(8'h01, r); xfer(8'h20, r); xfer(8'h55, r); desel();
    chk("R7 no busy", {31'd0, wip}, 32'd0);
    rd(16'h0120, d);
    chk("R7 write ignored", {24'd0, d}, 32'h81);

    // R5: cancelled write (deselect mid-byte)
    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h01, r); xfer(8'h20, r); xfer(8'h99, r);
    for (int i = 0; i < 4; i++) begin sclk = 1'b0; sdi = 1'b1; half(); sclk = 1'b1; half(); end
    desel();
    chk("R5 cancel no busy", {31'd0, wip}, 32'd0);
    rd(16'h0120, d);
    chk("R5 cancel keeps data", {24'd0, d}, 32'h81);
    rdsr(s);
    chk("R5 latch kept after cancel", {24'd0, s}, 32'h02);

    // R5 R8: page wrap write, busy length, latch cleared at end
    sel(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h5E, r);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r);
    if (!cpol) sclk = 1'b0;
    half();
    cs_n = 1'b1;
    cnt = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (wip) cnt++;
      else if (cnt > 0) break;
    end
    chk("R8 busy length", cnt, PROG);
    half();
    rdsr(s);
    chk("R8 latch cleared", {24'd0, s}, 32'h00);
    rd(16'h0040, d);
    chk("R5 page wrap", {24'd0, d}, 32'h33);
    sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h5E, r); xfer(8'h00, d); xfer(8'h00, d2); desel();
    chk("R4 stream first", {24'd0, d}, 32'h11);
    chk("R4 stream second", {24'd0, d2}, 32'h22);

    // R4: address wrap top to zero
    sel(); xfer(8'h03, r); xfer(8'h03, r); xfer(8'hFF, r); xfer(8'h00, d); xfer(8'h00, d2); desel();
    chk("R4 top byte", {24'd0, d}, 32'h3C);
    chk("R4 wrap to zero", {24'd0, d2}, 32'h00);

    // R9: during programming only status read served
    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h6B, r); desel();
    rdsr(s);
    chk("R9 status while busy", {24'd0, s}, 32'h03);
    sel(); xfer(8'h03, r); xfer(8'h01, r); xfer(8'h20, r);
    sclk = 1'b0; half();
    chk("R9 read ignored hiz", {31'd0, sdo === 1'bz}, 32'd1);
    desel();
    wait_idle();
    rd(16'h0200, d);
    chk("R9 write committed", {24'd0, d}, 32'h6B);

    // R10 R11: parked after latch set, no output
    sel(); xfer(8'h06, r); xfer(8'h05, r);
    sclk = 1'b0; half();
    chk("R10 parked hiz", {31'd0, sdo === 1'bz}, 32'd1);
    desel();
    chk("R11 deselected hiz", {31'd0, sdo === 1'bz}, 32'd1);
    // R2: status repeated while clocked
    sel(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, d); desel();
    chk("R2 status repeat", {24'd0, d}, 32'h02);

    // R12: status write
    sel(); xfer(8'h01, r); xfer(8'hFC, r); desel();
    wait_idle();
    rdsr(s);
    chk("R12 status stored", {24'd0, s}, 32'hFC);
    // R12: extra bit cancels
    cmd1(8'h06);
    sel(); xfer(8'h01, r); xfer(8'h00, r);
    sclk = 1'b0; sdi = 1'b0; half(); sclk = 1'b1; half();
    desel();
    wait_idle();
    rdsr(s);
    chk("R12 cancelled status write", {24'd0, s}, 32'hFE);

    // R1: idle-high clock read
    cpol = 1'b1; sclk = 1'b1; half();
    rd(16'h0120, d);
    chk("R1 mode 1,1 read", {24'd0, d}, 32'h81);
    cpol = 1'b0; sclk = 1'b0; half();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule